// File: doc/BRIEF.md
# Time Base with Drift-Free Interval Timer

This block keeps a 71-bit free-running time count that advances by one on each cycle in which the tick strobe is high. The tick stands for a 4.1 MHz rate. Software can load the count, but only its upper 59 bits; loading clears the lower 12 bits. A read strobe captures the count into a two-word snapshot. The high word holds bits 70..35. The low word holds bits 34..2 placed at bits 35..3. The two lowest bits of the count cannot be seen, and the final shift leaves the three lowest bits of the low word at zero.

A 35-bit interval register uses the same units as the count. The block keeps a 71-bit deadline. When a tick brings the count onto the deadline, the block pulses `intv_done_o` for one cycle, and that pulse feeds an external status flag. The next deadline is the old deadline plus the interval, not the time the expiry was seen plus the interval. Because of this, the average spacing of the pulses equals the programmed interval exactly, however the ticks are spread out. Writing the interval, or loading the time, re-arms the deadline at the new time plus the interval. An interval of zero produces no pulses.

Top module: `timebase_interval`

## Requirements
- R1: When `tick_i` is high and no time load is requested, the count grows by exactly one at the clock edge, wrapping from 2^71-1 to 0. Without a tick it holds.
- R2: When `time_wr_i` is high, the count becomes `{time_wdata_i, 12'b0}`. A load overrides a tick in the same cycle.
- R3: When `time_rd_i` is high, the count (as it was before that edge) is captured. After the edge, `time_hi_o` = count[70:35] and `time_lo_o` = {count[34:2], 3'b000}. Both words hold until the next read, whatever the count does in between.
- R4: When `intv_wr_i` is high, `intv_wdata_i` is stored, and `intv_o` shows it from the next cycle.
- R5: An interval write sets the deadline to the count after that edge plus the new interval. With interval N, the first pulse comes on the N-th tick that follows.
- R6: After each expiry, the next deadline is the old deadline plus the interval. Pulses therefore arrive every N ticks, however many idle cycles lie between ticks.
- R7: `intv_done_o` is high for exactly the one cycle after the edge at which a tick makes the count equal the deadline.
- R8: While the interval is zero, `intv_done_o` stays low.
- R9: If an expiry and an interval write fall in the same cycle, the pulse is still issued, and the deadline is re-armed from the new interval as in R5.
- R10: A time load suppresses any expiry in that cycle and re-arms the deadline to the loaded time plus the current interval.
- R11: After reset, the count, snapshot, interval and deadline are zero and `intv_done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-advance strobe, one per time unit |
| time_wr_i | input | 1 | Load the upper count bits |
| time_wdata_i | input | 59 | Value for count bits 70..12 |
| time_rd_i | input | 1 | Capture the count into the read words |
| time_hi_o | output | 36 | Snapshot count bits 70..35 |
| time_lo_o | output | 36 | Snapshot count bits 34..2, shifted left by three |
| intv_wr_i | input | 1 | Write the interval |
| intv_wdata_i | input | 35 | New interval value |
| intv_o | output | 35 | Current interval |
| intv_done_o | output | 1 | One-cycle pulse on each interval expiry |

## Verification
Two pairs of actions can land on the same edge. The first pair is an expiry and an interval rewrite. The bench arms an interval of 3, gives two ticks, and on the third tick also writes an interval of 5. It then expects a pulse on that cycle, no pulse for the next four ticks, and a pulse on the fifth. The second pair is an expiry and a time load. Here the bench expects the pulse to be dropped and the next one to come a full interval after the loaded value, which it confirms through a snapshot read.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  localparam int unsigned TB_CNT_W  = 71;
  localparam int unsigned TB_WR_W   = 59;
  localparam int unsigned TB_WORD_W = 36;
  localparam int unsigned TB_INTV_W = 35;
  localparam int unsigned TB_DROP_W = 2;
endpackage

// File: rtl/timebase_counter.sv
module timebase_counter #(
  parameter int unsigned CNT_W = timebase_pkg::TB_CNT_W,
  parameter int unsigned WR_W  = timebase_pkg::TB_WR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [WR_W-1:0]  load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam int unsigned FILL_W = CNT_W - WR_W;

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (load_i)      cnt_nxt_o = {load_val_i, {FILL_W{1'b0}}};
    else if (tick_i) cnt_nxt_o = cnt_q + 1'b1;
    else             cnt_nxt_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/timebase_snap.sv
module timebase_snap #(
  parameter int unsigned CNT_W  = timebase_pkg::TB_CNT_W,
  parameter int unsigned WORD_W = timebase_pkg::TB_WORD_W,
  parameter int unsigned DROP_W = timebase_pkg::TB_DROP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [WORD_W-1:0] hi_o,
  output logic [WORD_W-1:0] lo_o
);
  localparam int unsigned LO_BITS = CNT_W - WORD_W;
  localparam int unsigned LO_PAD  = WORD_W - LO_BITS + DROP_W;

  logic [CNT_W-1:DROP_W] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    snap_q <= '0;
    else if (cap_i) snap_q <= cnt_i[CNT_W-1:DROP_W];
  end

  assign hi_o = snap_q[CNT_W-1:LO_BITS];
  assign lo_o = {snap_q[LO_BITS-1:DROP_W], {LO_PAD{1'b0}}};

  logic unused_low;
  assign unused_low = ^cnt_i[DROP_W-1:0];
endmodule

// File: rtl/timebase_deadline.sv
module timebase_deadline #(
  parameter int unsigned CNT_W  = timebase_pkg::TB_CNT_W,
  parameter int unsigned INTV_W = timebase_pkg::TB_INTV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              time_wr_i,
  input  logic              intv_wr_i,
  input  logic [INTV_W-1:0] intv_wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  output logic [INTV_W-1:0] intv_o,
  output logic              done_o
);
  localparam int unsigned PAD_W = CNT_W - INTV_W;

  logic [INTV_W-1:0] intv_q, intv_nxt;
  logic [CNT_W-1:0]  dl_q;
  logic              done_q, hit;

  assign intv_nxt = intv_wr_i ? intv_wdata_i : intv_q;

  // expiry only when a real tick lands the count on the deadline
  assign hit = tick_i && !time_wr_i && (intv_q != '0) &&
               ((cnt_i + 1'b1) == dl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intv_q <= '0;
      dl_q   <= '0;
      done_q <= 1'b0;
    end else begin
      intv_q <= intv_nxt;
      done_q <= hit;
      if (intv_wr_i || time_wr_i)
        dl_q <= cnt_nxt_i + {{PAD_W{1'b0}}, intv_nxt};
      else if (hit)
        dl_q <= dl_q + {{PAD_W{1'b0}}, intv_q};
    end
  end

  assign intv_o = intv_q;
  assign done_o = done_q;
endmodule

// File: rtl/timebase_interval.sv
module timebase_interval #(
  parameter int unsigned CNT_W  = timebase_pkg::TB_CNT_W,
  parameter int unsigned WR_W   = timebase_pkg::TB_WR_W,
  parameter int unsigned WORD_W = timebase_pkg::TB_WORD_W,
  parameter int unsigned INTV_W = timebase_pkg::TB_INTV_W,
  parameter int unsigned DROP_W = timebase_pkg::TB_DROP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              time_wr_i,
  input  logic [WR_W-1:0]   time_wdata_i,
  input  logic              time_rd_i,
  output logic [WORD_W-1:0] time_hi_o,
  output logic [WORD_W-1:0] time_lo_o,
  input  logic              intv_wr_i,
  input  logic [INTV_W-1:0] intv_wdata_i,
  output logic [INTV_W-1:0] intv_o,
  output logic              intv_done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  timebase_counter #(.CNT_W(CNT_W), .WR_W(WR_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .load_i(time_wr_i), .load_val_i(time_wdata_i),
    .cnt_o(cnt_q), .cnt_nxt_o(cnt_nxt)
  );

  timebase_snap #(.CNT_W(CNT_W), .WORD_W(WORD_W), .DROP_W(DROP_W)) u_snap (
    .clk_i, .rst_ni, .cap_i(time_rd_i), .cnt_i(cnt_q),
    .hi_o(time_hi_o), .lo_o(time_lo_o)
  );

  timebase_deadline #(.CNT_W(CNT_W), .INTV_W(INTV_W)) u_dl (
    .clk_i, .rst_ni, .tick_i, .time_wr_i, .intv_wr_i, .intv_wdata_i,
    .cnt_i(cnt_q), .cnt_nxt_i(cnt_nxt),
    .intv_o, .done_o(intv_done_o)
  );
endmodule

// File: rtl/timebase_interval_chk.sv
module timebase_interval_chk #(
  parameter int unsigned CNT_W  = timebase_pkg::TB_CNT_W,
  parameter int unsigned WR_W   = timebase_pkg::TB_WR_W,
  parameter int unsigned WORD_W = timebase_pkg::TB_WORD_W,
  parameter int unsigned INTV_W = timebase_pkg::TB_INTV_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              time_wr_i,
  input logic [WR_W-1:0]   time_wdata_i,
  input logic              time_rd_i,
  input logic [WORD_W-1:0] time_hi_o,
  input logic [WORD_W-1:0] time_lo_o,
  input logic              intv_wr_i,
  input logic [INTV_W-1:0] intv_wdata_i,
  input logic [INTV_W-1:0] intv_o,
  input logic              intv_done_o,
  input logic [CNT_W-1:0]  cnt
);
  localparam int unsigned FILL_W = CNT_W - WR_W;

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !time_wr_i) |=> cnt == $past(cnt) + 1'b1);

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !time_wr_i) |=> $stable(cnt));

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_wr_i |=> (cnt[FILL_W-1:0] == '0) && (cnt[CNT_W-1:FILL_W] == $past(time_wdata_i)));

  p_lo_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_lo_o[2:0] == 3'b000);

  p_snap_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !time_rd_i |=> $stable(time_hi_o) && $stable(time_lo_o));

  p_intv_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intv_wr_i |=> intv_o == $past(intv_wdata_i));

  p_pulse_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intv_done_o |-> $past(tick_i) && !$past(time_wr_i));

  p_zero_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intv_done_o |-> $past(intv_o) != '0);
endmodule

bind timebase_interval timebase_interval_chk #(
  .CNT_W(CNT_W), .WR_W(WR_W), .WORD_W(WORD_W), .INTV_W(INTV_W)
) u_chk (
  .clk_i, .rst_ni, .tick_i, .time_wr_i, .time_wdata_i, .time_rd_i,
  .time_hi_o, .time_lo_o, .intv_wr_i, .intv_wdata_i, .intv_o,
  .intv_done_o, .cnt(cnt_q)
);

// File: tb/timebase_interval_test.sv
module timebase_interval_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        time_wr_i = 1'b0;
  logic [58:0] time_wdata_i = '0;
  logic        time_rd_i = 1'b0;
  logic [35:0] time_hi_o, time_lo_o;
  logic        intv_wr_i = 1'b0;
  logic [34:0] intv_wdata_i = '0;
  logic [34:0] intv_o;
  logic        intv_done_o;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  logic last_pulse;

  always #10 clk_i = ~clk_i;

  timebase_interval uut (.*);

  // {interval, idle cycles between ticks, tick count, expected pulses}
  localparam logic [31:0] VEC [6] = '{
    {8'd3, 8'd0, 8'd10, 8'd3},
    {8'd1, 8'd0, 8'd5,  8'd5},
    {8'd0, 8'd0, 8'd8,  8'd0},
    {8'd7, 8'd1, 8'd20, 8'd2},
    {8'd4, 8'd2, 8'd12, 8'd3},
    {8'd5, 8'd0, 8'd4,  8'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit t);
    tick_i = t;
    @(posedge clk_i); #1;
    tick_i = 1'b0; time_wr_i = 1'b0; intv_wr_i = 1'b0; time_rd_i = 1'b0;
    last_pulse = intv_done_o;
    if (intv_done_o) pulses++;
  endtask

  task automatic set_intv(input logic [34:0] v, input bit t);
    intv_wr_i = 1'b1; intv_wdata_i = v; cyc(t);
  endtask

  task automatic set_time(input logic [58:0] v, input bit t);
    time_wr_i = 1'b1; time_wdata_i = v; cyc(t);
  endtask

  task automatic rd_check(input logic [70:0] e, input string req);
    time_rd_i = 1'b1; cyc(1'b0);
    chk(time_hi_o == e[70:35], req, 72'(time_hi_o), 72'(e[70:35]));
    chk(time_lo_o == {e[34:2], 3'b000}, req, 72'(time_lo_o), 72'({e[34:2], 3'b000}));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [70:0] e;
    logic [58:0] w;
    #25 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // R11 reset state
    chk(time_hi_o == '0 && time_lo_o == '0, "R11 snapshot", 72'(time_hi_o), 72'd0);
    chk(intv_o == '0 && intv_done_o == 1'b0, "R11 interval", 72'(intv_o), 72'd0);
    rd_check(71'd0, "R11 count");

    // R5 R6 R7 R8 vector table
    for (int i = 0; i < 6; i++) begin
      set_intv(35'(VEC[i][31:24]), 1'b0);
      pulses = 0;
      for (int k = 0; k < int'(VEC[i][15:8]); k++) begin
        for (int g = 0; g < int'(VEC[i][23:16]); g++) cyc(1'b0);
        cyc(1'b1);
      end
      cyc(1'b0);
      chk(pulses == int'(VEC[i][7:0]), "R6 pulse count", 72'(pulses), 72'(VEC[i][7:0]));
    end

    // R4 interval readback
    set_intv(35'h5_5555_5555, 1'b0);
    chk(intv_o == 35'h5_5555_5555, "R4 readback", 72'(intv_o), 72'h5_5555_5555);

    // R2 R3 load then read, low bits hidden
    w = 59'h123_4567_89AB_CDEF;
    set_time(w, 1'b1);
    e = {w, 12'b0};
    rd_check(e, "R2 load");
    for (int k = 0; k < 3; k++) cyc(1'b1);
    rd_check(e + 71'd3, "R3 low bits hidden");
    cyc(1'b1);
    rd_check(e + 71'd4, "R3 bit2 visible");
    // R3 snapshot holds while count moves
    for (int k = 0; k < 9; k++) cyc(1'b1);
    chk(time_lo_o == {e[34:2] + 33'd1, 3'b000}, "R3 snapshot hold", 72'(time_lo_o), 72'({e[34:2] + 33'd1, 3'b000}));

    // R1 carry across word boundary and full wrap
    set_time(59'h7F_FFFF, 1'b0);
    for (int k = 0; k < 4096; k++) cyc(1'b1);
    rd_check(71'h8_0000_0000, "R1 carry");
    set_time({59{1'b1}}, 1'b0);
    for (int k = 0; k < 4095; k++) cyc(1'b1);
    rd_check({71{1'b1}}, "R1 top");
    cyc(1'b1);
    rd_check(71'd0, "R1 wrap");

    // R9 expiry and interval write in the same cycle
    set_intv(35'd3, 1'b0);
    cyc(1'b1); cyc(1'b1);
    set_intv(35'd5, 1'b1);
    chk(last_pulse == 1'b1, "R9 pulse kept", 72'(last_pulse), 72'd1);
    pulses = 0;
    for (int k = 0; k < 4; k++) cyc(1'b1);
    chk(pulses == 0, "R9 no early pulse", 72'(pulses), 72'd0);
    cyc(1'b1);
    chk(last_pulse == 1'b1, "R9 rearm from new interval", 72'(last_pulse), 72'd1);

    // R10 time load suppresses expiry and re-arms
    set_intv(35'd3, 1'b0);
    cyc(1'b1); cyc(1'b1);
    w = 59'h42;
    set_time(w, 1'b1);
    chk(last_pulse == 1'b0, "R10 suppressed", 72'(last_pulse), 72'd0);
    pulses = 0;
    cyc(1'b1); cyc(1'b1);
    chk(pulses == 0, "R10 no early pulse", 72'(pulses), 72'd0);
    cyc(1'b1);
    chk(last_pulse == 1'b1, "R10 rearmed", 72'(last_pulse), 72'd1);
    rd_check({w, 12'b0} + 71'd3, "R10 count");

    // R7 single-cycle pulse with sparse ticks
    set_intv(35'd2, 1'b0);
    cyc(1'b1); cyc(1'b1);
    chk(last_pulse == 1'b1, "R7 pulse", 72'(last_pulse), 72'd1);
    cyc(1'b0);
    chk(last_pulse == 1'b0, "R7 one cycle", 72'(last_pulse), 72'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule